// File: doc/BRIEF.md
# Transmit Offload Context Tracker

This block sits in a transmit path and sees descriptors one at a time. A descriptor is either a context descriptor, which loads offload settings, or a data descriptor. A data descriptor selects one of three offload modes: legacy, extended or segmentation. The tracker keeps one dedicated context store for the extended mode and one for the segmentation mode. Each accepted data descriptor comes out one cycle later with its resolved mode and the fields of the matching store. A loaded store stays in force for any number of packets until another context descriptor rewrites it.

The tracker also enforces ordering. A context descriptor may not arrive inside an open packet. All data descriptors of one packet must share one mode. An extended or segmentation data descriptor needs a loaded context. Each broken rule sets its own sticky error bit, and the offending descriptor has no effect on the stores. When a context is accepted, the block emits a one-cycle pulse so that a downstream request pipeline can drain before the new settings apply.

Top module: `txctx_tracker`

## Requirements
- R1: While reset is asserted and on the first sample after it, outValid, ctxChange and all errFlags bits are 0, and both context stores are invalid and zero.
- R2: A data descriptor (descKind 01 = legacy, 10 = extended, 11 = segmentation) with descValid high at a rising edge raises outValid for exactly the following cycle. When it opens a packet, outMode equals its descKind.
- R3: A context descriptor (descKind 00) accepted outside a packet writes descFields into the extended store when descSel is 0, or into the segmentation store when descSel is 1. An emitted extended or segmentation descriptor carries that store's contents on outCtx, and a legacy descriptor carries zero.
- R4: A store keeps its contents across any number of packets until a context descriptor rewrites it. Writing one store leaves the other unchanged.
- R5: ctxChange is high for exactly one cycle after each accepted context descriptor, and at no other time.
- R6: A context descriptor that arrives while a packet is open sets errFlags[0]. It changes no store, raises no ctxChange and emits nothing.
- R7: A data descriptor whose kind differs from the mode of the open packet sets errFlags[1]. It is emitted with the packet's mode and that mode's context.
- R8: A data descriptor with descEop high closes the packet. The next data descriptor opens a new packet in whatever mode it carries.
- R9: An extended or segmentation data descriptor that opens a packet while its store has never been loaded since reset sets errFlags[2]. It is emitted with outCtx equal to zero.
- R10: errFlags bits, once set, stay set until reset.
- R11: A cycle with descValid low emits nothing, raises no ctxChange and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| descValid | input | 1 | Descriptor present this cycle |
| descKind | input | 2 | 00 context, 01 legacy, 10 extended, 11 segmentation |
| descSel | input | 1 | Context target: 0 extended store, 1 segmentation store |
| descEop | input | 1 | Data descriptor ends the packet |
| descFields | input | CTX_W | Context payload for a context descriptor |
| outValid | output | 1 | Resolved data descriptor present |
| outMode | output | 2 | Resolved mode, same encoding as descKind |
| outCtx | output | CTX_W | Context fields applied to the descriptor |
| ctxChange | output | 1 | One-cycle pulse after a context load |
| errFlags | output | 3 | Sticky: [0] context mid-packet, [1] mode mix, [2] missing context |

## Verification
The bench sweeps every ordered triple of descriptor kinds under every pattern of end-of-packet bits, and it alternates the context target. This drives context loads both inside and outside open packets, single-descriptor and multi-descriptor packets, and every pairing of packet mode with a later descriptor's kind. Single-descriptor packets separate an open packet from a closed one. Mixed kinds inside a packet separate the packet's mode from the descriptor's own kind. Each end-of-packet pattern begins from a fresh reset, so data descriptors that reach a never-loaded store are checked separately from ones that reach a loaded store. Idle cycles between the triples confirm that nothing moves without a valid descriptor.

// File: rtl/txctx_pkg.sv
package txctx_pkg;

  typedef enum logic [1:0] {
    KIND_CTX    = 2'b00,
    KIND_LEGACY = 2'b01,
    KIND_EXT    = 2'b10,
    KIND_SEG    = 2'b11
  } descKind_t;

  localparam int ERR_W       = 3;
  localparam int ERR_CTX_MID = 0;
  localparam int ERR_MIX     = 1;
  localparam int ERR_NO_CTX  = 2;
  localparam int NUM_STORES  = 2;
  localparam int STORE_EXT   = 0;
  localparam int STORE_SEG   = 1;

  typedef struct packed {
    logic [NUM_STORES-1:0] wrStore;
    logic                  emit;
    descKind_t             emitMode;
    logic [ERR_W-1:0]      errSet;
  } ctrlStrobe_t;

endpackage

// File: rtl/txctx_ctrl.sv
module txctx_ctrl
  import txctx_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  descValid,
  input  descKind_t             descKind,
  input  logic                  descSel,
  input  logic                  descEop,
  input  logic [NUM_STORES-1:0] storeValid,
  output ctrlStrobe_t           strobe,
  output logic [ERR_W-1:0]      errFlags
);

  logic      inPacket;
  descKind_t pktMode;
  logic      needCtx;

  always_comb begin
    strobe  = '0;
    needCtx = 1'b0;
    if (descValid) begin
      if (descKind == KIND_CTX) begin
        if (inPacket) begin
          strobe.errSet[ERR_CTX_MID] = 1'b1;
        end else if (descSel) begin
          strobe.wrStore[STORE_SEG] = 1'b1;
        end else begin
          strobe.wrStore[STORE_EXT] = 1'b1;
        end
      end else begin
        strobe.emit = 1'b1;
        if (!inPacket) begin
          strobe.emitMode = descKind;
          needCtx = ((descKind == KIND_EXT) && !storeValid[STORE_EXT]) ||
                    ((descKind == KIND_SEG) && !storeValid[STORE_SEG]);
          strobe.errSet[ERR_NO_CTX] = needCtx;
        end else begin
          strobe.emitMode = pktMode;
          strobe.errSet[ERR_MIX] = (descKind != pktMode);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inPacket <= 1'b0;
      pktMode  <= KIND_LEGACY;
      errFlags <= '0;
    end else begin
      errFlags <= errFlags | strobe.errSet;
      if (strobe.emit) begin
        inPacket <= !descEop;
        if (!inPacket) pktMode <= descKind;
      end
    end
  end

  // R6: no context store may be written while a packet is open
  p_no_write_midpkt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    inPacket |-> (strobe.wrStore == '0));

  // R3: at most one store is written per cycle
  p_single_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe.wrStore));

  // R10: error bits never clear outside reset
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

  // R8: an open packet only arises from a data descriptor without end-of-packet
  p_open_needs_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inPacket) |-> $past(strobe.emit && !descEop));

endmodule

// File: rtl/txctx_datapath.sv
module txctx_datapath
  import txctx_pkg::*;
#(
  parameter int CTX_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctrlStrobe_t           strobe,
  input  logic [CTX_W-1:0]      descFields,
  output logic [NUM_STORES-1:0] storeValid,
  output logic                  outValid,
  output descKind_t             outMode,
  output logic [CTX_W-1:0]      outCtx,
  output logic                  ctxChange
);

  logic [CTX_W-1:0] storeData [NUM_STORES];
  logic [CTX_W-1:0] selCtx;

  for (genvar g = 0; g < NUM_STORES; g++) begin : gStore
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        storeData[g]  <= '0;
        storeValid[g] <= 1'b0;
      end else if (strobe.wrStore[g]) begin
        storeData[g]  <= descFields;
        storeValid[g] <= 1'b1;
      end
    end

    // R4: a store holds its value whenever it is not written
    p_store_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe.wrStore[g] |=> $stable(storeData[g]));
  end

  always_comb begin
    unique case (strobe.emitMode)
      KIND_EXT: selCtx = storeData[STORE_EXT];
      KIND_SEG: selCtx = storeData[STORE_SEG];
      default:  selCtx = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid  <= 1'b0;
      outMode   <= KIND_CTX;
      outCtx    <= '0;
      ctxChange <= 1'b0;
    end else begin
      outValid  <= strobe.emit;
      outMode   <= strobe.emit ? strobe.emitMode : KIND_CTX;
      outCtx    <= strobe.emit ? selCtx : '0;
      ctxChange <= |strobe.wrStore;
    end
  end

  // R5: a context pulse never coincides with an emitted data descriptor
  p_chg_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctxChange |-> !outValid);

  // R3: legacy descriptors carry no context
  p_legacy_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && outMode == KIND_LEGACY) |-> (outCtx == '0));

  // R2: emitted descriptors always carry a data mode
  p_mode_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> (outMode != KIND_CTX));

endmodule

// File: rtl/txctx_tracker.sv
module txctx_tracker
  import txctx_pkg::*;
#(
  parameter int CTX_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             descValid,
  input  logic [1:0]       descKind,
  input  logic             descSel,
  input  logic             descEop,
  input  logic [CTX_W-1:0] descFields,
  output logic             outValid,
  output logic [1:0]       outMode,
  output logic [CTX_W-1:0] outCtx,
  output logic             ctxChange,
  output logic [ERR_W-1:0] errFlags
);

  ctrlStrobe_t           strobe;
  logic [NUM_STORES-1:0] storeValid;
  descKind_t             modeOut;

  txctx_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .descValid  (descValid),
    .descKind   (descKind_t'(descKind)),
    .descSel    (descSel),
    .descEop    (descEop),
    .storeValid (storeValid),
    .strobe     (strobe),
    .errFlags   (errFlags)
  );

  txctx_datapath #(.CTX_W(CTX_W)) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .descFields (descFields),
    .storeValid (storeValid),
    .outValid   (outValid),
    .outMode    (modeOut),
    .outCtx     (outCtx),
    .ctxChange  (ctxChange)
  );

  assign outMode = modeOut;

endmodule

// File: tb/txctx_tracker_bench.sv
`timescale 1ns/1ps
module txctx_tracker_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        descValid;
  logic [1:0]  descKind;
  logic        descSel;
  logic        descEop;
  logic [31:0] descFields;
  logic        outValid;
  logic [1:0]  outMode;
  logic [31:0] outCtx;
  logic        ctxChange;
  logic [2:0]  errFlags;

  int checks = 0;
  int errors = 0;

  // independent model state
  logic        mInPkt;
  logic [1:0]  mPktMode;
  logic [31:0] mExt, mSeg;
  logic [2:0]  mErr;
  int          descCount = 0;

  always #10 clk = ~clk;

  txctx_tracker #(.CTX_W(32)) u_txctx_tracker (
    .clk(clk), .rst_n(rst_n), .descValid(descValid), .descKind(descKind),
    .descSel(descSel), .descEop(descEop), .descFields(descFields),
    .outValid(outValid), .outMode(outMode), .outCtx(outCtx),
    .ctxChange(ctxChange), .errFlags(errFlags)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; descValid = 1'b0; descKind = 2'b00; descSel = 1'b0;
    descEop = 1'b0; descFields = '0;
    repeat (2) @(posedge clk);
    #5;
    chk(outValid == 1'b0, "R1", "outValid", 32'(outValid), 0);
    chk(ctxChange == 1'b0, "R1", "ctxChange", 32'(ctxChange), 0);
    chk(errFlags == 3'b000, "R1", "errFlags", 32'(errFlags), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #5;
    chk(outValid == 1'b0 && errFlags == 3'b000, "R1", "post-reset",
        {29'd0, errFlags}, 0);
    mInPkt = 1'b0; mPktMode = 2'b01; mExt = '0; mSeg = '0; mErr = '0;
  endtask

  task automatic sendDesc(input logic [1:0] k, input logic s, input logic e,
                          input logic [31:0] f);
    logic        eValid, eChg;
    logic [1:0]  eMode;
    logic [31:0] eCtx;
    string       modeTag, ctxTag, errTag;
    logic [1:0]  useMode;
    @(negedge clk);
    descValid = 1'b1; descKind = k; descSel = s; descEop = e; descFields = f;
    eValid = 1'b0; eChg = 1'b0; eMode = 2'b00; eCtx = '0;
    modeTag = "R2"; ctxTag = "R3/R4"; errTag = "R10";
    if (k == 2'b00) begin
      if (mInPkt) begin
        mErr[0] = 1'b1; errTag = "R6";
      end else begin
        eChg = 1'b1;
        if (s) mSeg = f; else mExt = f;
      end
    end else begin
      eValid = 1'b1;
      if (!mInPkt) begin
        useMode = k;
        modeTag = "R8";
        if ((k == 2'b10 && !(mExt != 0 || extLoaded)) ||
            (k == 2'b11 && !(mSeg != 0 || segLoaded))) begin
          mErr[2] = 1'b1; errTag = "R9"; ctxTag = "R9";
        end
        mPktMode = k;
      end else begin
        useMode = mPktMode;
        if (k != mPktMode) begin
          mErr[1] = 1'b1; errTag = "R7"; modeTag = "R7"; ctxTag = "R7";
        end
      end
      eMode = useMode;
      eCtx = (useMode == 2'b10) ? mExt : (useMode == 2'b11) ? mSeg : 32'd0;
      mInPkt = !e;
    end
    if (k == 2'b00 && !eChg) begin
      // rejected: stores untouched
    end else if (k == 2'b00) begin
      if (s) segLoaded = 1'b1; else extLoaded = 1'b1;
    end
    @(posedge clk);
    #5;
    chk(outValid == eValid, modeTag, "outValid", 32'(outValid), 32'(eValid));
    if (eValid) begin
      chk(outMode == eMode, modeTag, "outMode", 32'(outMode), 32'(eMode));
      chk(outCtx == eCtx, ctxTag, "outCtx", outCtx, eCtx);
    end
    chk(ctxChange == eChg, (k == 2'b00 && !eChg) ? "R6" : "R5", "ctxChange",
        32'(ctxChange), 32'(eChg));
    chk(errFlags == mErr, errTag, "errFlags", 32'(errFlags), 32'(mErr));
    descCount++;
  endtask

  logic extLoaded, segLoaded;

  task automatic idleCheck();
    @(negedge clk);
    descValid = 1'b0; descKind = 2'b00; descFields = 32'hDEAD_BEEF;
    @(posedge clk);
    #5;
    chk(outValid == 1'b0 && ctxChange == 1'b0, "R11", "idle out/pulse",
        {30'd0, outValid, ctxChange}, 0);
    chk(errFlags == mErr, "R11", "idle errFlags", 32'(errFlags), 32'(mErr));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; descValid = 1'b0; descKind = 2'b00; descSel = 1'b0;
    descEop = 1'b0; descFields = '0;
    for (int ep = 0; ep < 8; ep++) begin
      doReset();
      extLoaded = 1'b0; segLoaded = 1'b0;
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          for (int c = 0; c < 4; c++) begin
            sendDesc(2'(a), 1'((descCount >> 1) & 1), 1'(ep & 1),
                     32'h1000_0000 + 32'(descCount) * 32'h0001_0101 + 32'd1);
            sendDesc(2'(b), 1'((descCount >> 1) & 1), 1'((ep >> 1) & 1),
                     32'h2000_0000 + 32'(descCount) * 32'h0001_0101 + 32'd1);
            sendDesc(2'(c), 1'((descCount >> 1) & 1), 1'((ep >> 2) & 1),
                     32'h3000_0000 + 32'(descCount) * 32'h0001_0101 + 32'd1);
            idleCheck();
          end
        end
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule